// File: doc/BRIEF.md
# MMU Access Verdict Unit

This block judges each memory access against the translation permission and attribute rules and returns one outcome per request. An access arrives as a single-cycle request. It carries the side (instruction fetch or data access), an opcode class, an address-space class, the privileged-mode flag, the address-mask flag and a flag that says whether the virtual address is in range. The same cycle carries the translation lookup result (hit, privileged-page, writable, side-effect, physically-cacheable and no-fault-only bits) and the translation enable for the side that makes the access.

One cycle after the request strobe, the unit presents a verdict code and a fault-type code together with an output-valid flag. The verdict is one of: pass, data miss, instruction miss, data exception, instruction exception, data protection fault or privileged-action trap. Between requests the result stays stable.

The control is a two-state machine. In `ST_IDLE` no result is on offer. In `ST_EMIT` a fresh result is on offer. The transition `go_emit` (IDLE to EMIT) and the transition `stay_emit` (EMIT to EMIT) are both taken on a request strobe. The transition `go_idle` (EMIT to IDLE) and the transition `stay_idle` (IDLE to IDLE) are both taken when no request arrives.

Top module: `mmu_access_judge`

## Requirements
- R1: The verdict is registered. `out_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1, and the result captured at that edge is presented then. Without a request, `out_verdict` and `out_ftype` keep their values. After reset, `out_valid`, `out_verdict` and `out_ftype` are all 0.
- R2: The verdict codes are: 0 pass, 1 data miss, 2 instruction miss, 3 data exception, 4 instruction exception, 5 data protection, 6 privileged action. `out_ftype` is 0 for pass and for both miss codes. It is nonzero for every fault.
- R3: On the data side, when `req_priv`=0 and the address-space class is restricted, the verdict is 6 with fault type 0x08. The restricted classes are nucleus (2), as-user (3) and bypass (4). This check outranks every other check.
- R4: A data access with the bypass class (4) and `req_priv`=1 always passes, whatever the lookup, range and enable inputs.
- R5: With `mmu_en`=0, a data atomic (`req_op`=2) gives verdict 3 with fault type 0x04. Every other data access passes, and every instruction fetch passes. No miss is ever reported while translation is off.
- R6: A data access of any opcode, flush (3) included, with `req_va_ok`=0 and `req_am`=0 gives verdict 3 with fault type 0x20. With `req_am`=1 the range flag is ignored.
- R7: A lookup miss gives verdict 1 on the data side and verdict 2 on the instruction side, in either privilege mode.
- R8: A hit on a page with P=1 while `req_priv`=0 gives verdict 3 with fault type 0x01 on the data side, and verdict 4 with fault type 0x01 on the instruction side.
- R9: An atomic to a page with CP=0 gives verdict 3 with fault type 0x04.
- R10: A data access to a page with NFO=1 gives verdict 3 with fault type 0x10, unless its class is no-fault (1).
- R11: A load (`req_op`=0) with the no-fault class (1) to a page with E=1 gives verdict 3 with fault type 0x02.
- R12: A store (1) or atomic (2) to a page with W=0 gives verdict 5 with fault type 0x40. Loads and flushes ignore W.
- R13: When several data rules apply at once, the highest-priority rule decides. The order from highest is: privileged action, bypass pass, translation off, address range, miss, privileged page, cacheable atomic, no-fault-only, side effect, write protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_is_inst | input | 1 | 1 = instruction fetch, 0 = data access |
| req_op | input | 2 | Opcode class: 0 load, 1 store, 2 atomic, 3 flush |
| req_asi | input | 3 | Address-space class: 0 normal, 1 no-fault, 2 nucleus, 3 as-user, 4 bypass |
| req_priv | input | 1 | Privileged mode |
| req_am | input | 1 | Address-mask flag |
| req_va_ok | input | 1 | Virtual address in range |
| mmu_en | input | 1 | Translation enable for the requesting side |
| tlb_hit | input | 1 | Lookup hit |
| tlb_p | input | 1 | Privileged page |
| tlb_w | input | 1 | Writable page |
| tlb_e | input | 1 | Page has side effects |
| tlb_cp | input | 1 | Physically cacheable page |
| tlb_nfo | input | 1 | No-fault-only page |
| out_valid | output | 1 | Result valid |
| out_verdict | output | 3 | Verdict code |
| out_ftype | output | 8 | Fault-type code |

## Verification
The bench drives requests in which two or three rules hold at once. Each of these combinations is built so that a single swapped priority level shows up as the wrong verdict or the wrong fault type. One such case is a miss paired with an out-of-range address, where a swapped order would report a miss instead of the range exception.

The bench also covers the escape conditions. These include the no-fault class passing a no-fault-only page, the address mask hiding a range error, a flush to a read-only page, and privileged bypass suppressing every other fault. A design that lost one of these escapes would raise a trap that should not happen.

Translation-off requests check that misses vanish while the atomic check remains. An idle cycle after a fault checks that the registered result holds and that the valid flag drops.

// File: rtl/mmuj_pkg.sv
package mmuj_pkg;

    localparam int OP_W  = 2;
    localparam int ASI_W = 3;
    localparam int VRD_W = 3;
    localparam int FT_W  = 8;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_ATOMIC = 2'd2,
        OP_FLUSH  = 2'd3
    } op_e;

    typedef enum logic [ASI_W-1:0] {
        ASI_NORMAL  = 3'd0,
        ASI_NOFAULT = 3'd1,
        ASI_NUCLEUS = 3'd2,
        ASI_ASUSER  = 3'd3,
        ASI_BYPASS  = 3'd4
    } asi_e;

    typedef enum logic [VRD_W-1:0] {
        V_OK      = 3'd0,
        V_DMISS   = 3'd1,
        V_IMISS   = 3'd2,
        V_DEXC    = 3'd3,
        V_IEXC    = 3'd4,
        V_DPROT   = 3'd5,
        V_PRIVACT = 3'd6
    } verdict_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } st_e;

    localparam logic [FT_W-1:0] FT_NONE      = 8'h00;
    localparam logic [FT_W-1:0] FT_PRIV_PAGE = 8'h01;
    localparam logic [FT_W-1:0] FT_SIDE_EFF  = 8'h02;
    localparam logic [FT_W-1:0] FT_NC_ATOMIC = 8'h04;
    localparam logic [FT_W-1:0] FT_PRIVACT   = 8'h08;
    localparam logic [FT_W-1:0] FT_NFO       = 8'h10;
    localparam logic [FT_W-1:0] FT_VA_RANGE  = 8'h20;
    localparam logic [FT_W-1:0] FT_WPROT     = 8'h40;

    typedef struct packed {
        logic hit;
        logic p;
        logic w;
        logic e;
        logic cp;
        logic nfo;
    } tte_t;

    typedef struct packed {
        verdict_e          v;
        logic [FT_W-1:0]   ft;
    } result_t;

endpackage

// File: rtl/mmuj_data_rules.sv
module mmuj_data_rules
    import mmuj_pkg::*;
(
    input  op_e     op,
    input  asi_e    asi,
    input  logic    priv,
    input  logic    am,
    input  logic    va_ok,
    input  logic    en,
    input  tte_t    tte,
    output result_t res
);

    logic restricted;
    logic is_atomic;
    logic writes;
    logic nf_class;

    always_comb begin
        restricted = (asi == ASI_NUCLEUS) || (asi == ASI_ASUSER) || (asi == ASI_BYPASS);
        is_atomic  = (op == OP_ATOMIC);
        writes     = (op == OP_STORE) || is_atomic;
        nf_class   = (asi == ASI_NOFAULT);
    end

    // Priority chain: the first rule that matches decides the verdict.
    always_comb begin
        res.v  = V_OK;
        res.ft = FT_NONE;
        if (restricted && !priv) begin
            res.v  = V_PRIVACT;
            res.ft = FT_PRIVACT;
        end else if (asi == ASI_BYPASS) begin
            res.v  = V_OK;
        end else if (!en) begin
            if (is_atomic) begin
                res.v  = V_DEXC;
                res.ft = FT_NC_ATOMIC;
            end
        end else if (!va_ok && !am) begin
            res.v  = V_DEXC;
            res.ft = FT_VA_RANGE;
        end else if (!tte.hit) begin
            res.v  = V_DMISS;
        end else if (tte.p && !priv) begin
            res.v  = V_DEXC;
            res.ft = FT_PRIV_PAGE;
        end else if (is_atomic && !tte.cp) begin
            res.v  = V_DEXC;
            res.ft = FT_NC_ATOMIC;
        end else if (tte.nfo && !nf_class) begin
            res.v  = V_DEXC;
            res.ft = FT_NFO;
        end else if (nf_class && tte.e && (op == OP_LOAD)) begin
            res.v  = V_DEXC;
            res.ft = FT_SIDE_EFF;
        end else if (writes && !tte.w) begin
            res.v  = V_DPROT;
            res.ft = FT_WPROT;
        end
    end

endmodule

// File: rtl/mmuj_inst_rules.sv
module mmuj_inst_rules
    import mmuj_pkg::*;
(
    input  logic    priv,
    input  logic    en,
    input  logic    hit,
    input  logic    p,
    output result_t res
);

    always_comb begin
        res.v  = V_OK;
        res.ft = FT_NONE;
        if (!en) begin
            res.v  = V_OK;
        end else if (!hit) begin
            res.v  = V_IMISS;
        end else if (p && !priv) begin
            res.v  = V_IEXC;
            res.ft = FT_PRIV_PAGE;
        end
    end

endmodule

// File: rtl/mmu_access_judge.sv
module mmu_access_judge
    import mmuj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_inst,
    input  logic [OP_W-1:0]   req_op,
    input  logic [ASI_W-1:0]  req_asi,
    input  logic              req_priv,
    input  logic              req_am,
    input  logic              req_va_ok,
    input  logic              mmu_en,
    input  logic              tlb_hit,
    input  logic              tlb_p,
    input  logic              tlb_w,
    input  logic              tlb_e,
    input  logic              tlb_cp,
    input  logic              tlb_nfo,
    output logic              out_valid,
    output logic [VRD_W-1:0]  out_verdict,
    output logic [FT_W-1:0]   out_ftype
);

    tte_t    tte;
    result_t res_d;
    result_t res_i;
    result_t res_sel;
    st_e     state_q;
    st_e     state_d;

    assign tte = '{hit: tlb_hit, p: tlb_p, w: tlb_w, e: tlb_e, cp: tlb_cp, nfo: tlb_nfo};

    mmuj_data_rules u_data (
        .op    (op_e'(req_op)),
        .asi   (asi_e'(req_asi)),
        .priv  (req_priv),
        .am    (req_am),
        .va_ok (req_va_ok),
        .en    (mmu_en),
        .tte   (tte),
        .res   (res_d)
    );

    mmuj_inst_rules u_inst (
        .priv (req_priv),
        .en   (mmu_en),
        .hit  (tlb_hit),
        .p    (tlb_p),
        .res  (res_i)
    );

    assign res_sel = req_is_inst ? res_i : res_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: go_emit / stay_emit on a strobe, go_idle / stay_idle without
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = req_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_verdict <= '0;
            out_ftype   <= '0;
        end else if (req_valid) begin
            out_verdict <= res_sel.v;
            out_ftype   <= res_sel.ft;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

    // R1: one-cycle registered handshake and hold
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    a_r1_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(out_verdict) && $stable(out_ftype)));

    // R2: fault type is zero for pass and miss, nonzero otherwise
    a_r2_ft_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_verdict <= 3'd2) |-> (out_ftype == '0));
    a_r2_ft_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_verdict >= 3'd3) |-> (out_ftype != '0));

    // R3: restricted class without privilege
    a_r3_privact: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_inst && !req_priv && req_asi >= 3'd2 && req_asi <= 3'd4)
        |=> (out_verdict == 3'd6 && out_ftype == 8'h08));

    // R4: privileged bypass never faults
    a_r4_bypass_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_inst && req_priv && req_asi == 3'd4) |=> (out_verdict == 3'd0));

    // R5: no miss while translation is off
    a_r5_no_miss_off: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mmu_en) |=> (out_verdict != 3'd1 && out_verdict != 3'd2));

endmodule

// File: tb/sim_mmu_access_judge.sv
`timescale 1ns/1ps
module sim_mmu_access_judge;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_is_inst = 1'b0;
    logic [1:0] req_op = '0;
    logic [2:0] req_asi = '0;
    logic req_priv = 0, req_am = 0, req_va_ok = 1, mmu_en = 1;
    logic tlb_hit = 1, tlb_p = 0, tlb_w = 1, tlb_e = 0, tlb_cp = 1, tlb_nfo = 0;
    logic out_valid;
    logic [2:0] out_verdict;
    logic [7:0] out_ftype;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mmu_access_judge u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_inst(req_is_inst),
        .req_op(req_op), .req_asi(req_asi), .req_priv(req_priv), .req_am(req_am),
        .req_va_ok(req_va_ok), .mmu_en(mmu_en), .tlb_hit(tlb_hit), .tlb_p(tlb_p),
        .tlb_w(tlb_w), .tlb_e(tlb_e), .tlb_cp(tlb_cp), .tlb_nfo(tlb_nfo),
        .out_valid(out_valid), .out_verdict(out_verdict), .out_ftype(out_ftype)
    );

    // {rid[4], inst, op[2], asi[3], priv, am, vaok, en, hit, p, w, e, cp, nfo, ev[3], ef[8]}
    function automatic logic [30:0] vec(input logic [3:0] rid, input logic inst,
        input logic [1:0] op, input logic [2:0] asi, input logic priv, input logic am,
        input logic vaok, input logic en, input logic hit, input logic p, input logic w,
        input logic e, input logic cp, input logic nfo, input logic [2:0] ev, input logic [7:0] ef);
        return {rid, inst, op, asi, priv, am, vaok, en, hit, p, w, e, cp, nfo, ev, ef};
    endfunction

    localparam int NV = 27;
    localparam logic [30:0] VT [NV] = '{
        //      rid  in op  asi pr am va en ht p  w  e  cp nf  ev    ef
        vec(4'd2,  0, 0, 0, 0, 0, 1, 1, 1, 0, 1, 0, 1, 0, 3'd0, 8'h00), // R2 plain load
        vec(4'd7,  0, 0, 0, 0, 0, 1, 1, 0, 0, 1, 0, 1, 0, 3'd1, 8'h00), // R7 data miss
        vec(4'd7,  1, 0, 0, 1, 0, 1, 1, 0, 0, 1, 0, 1, 0, 3'd2, 8'h00), // R7 inst miss, priv
        vec(4'd8,  0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0, 1, 0, 3'd3, 8'h01), // R8 data priv page
        vec(4'd8,  1, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0, 1, 0, 3'd4, 8'h01), // R8 inst priv page
        vec(4'd8,  0, 0, 0, 1, 0, 1, 1, 1, 1, 1, 0, 1, 0, 3'd0, 8'h00), // R8 privileged ok
        vec(4'd9,  0, 2, 0, 0, 0, 1, 1, 1, 0, 1, 0, 0, 0, 3'd3, 8'h04), // R9 atomic uncached
        vec(4'd5,  0, 2, 0, 0, 0, 1, 0, 0, 0, 1, 0, 1, 0, 3'd3, 8'h04), // R5 off, atomic
        vec(4'd5,  0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 3'd0, 8'h00), // R5 off, store
        vec(4'd6,  0, 3, 0, 0, 0, 0, 1, 1, 0, 1, 0, 1, 0, 3'd3, 8'h20), // R6 flush range
        vec(4'd6,  0, 0, 0, 0, 1, 0, 1, 1, 0, 1, 0, 1, 0, 3'd0, 8'h00), // R6 masked
        vec(4'd10, 0, 0, 0, 0, 0, 1, 1, 1, 0, 1, 0, 1, 1, 3'd3, 8'h10), // R10 nfo normal
        vec(4'd10, 0, 0, 1, 0, 0, 1, 1, 1, 0, 1, 0, 1, 1, 3'd0, 8'h00), // R10 nfo no-fault
        vec(4'd11, 0, 0, 1, 0, 0, 1, 1, 1, 0, 1, 1, 1, 0, 3'd3, 8'h02), // R11 nf load E
        vec(4'd11, 0, 0, 0, 0, 0, 1, 1, 1, 0, 1, 1, 1, 0, 3'd0, 8'h00), // R11 normal load E
        vec(4'd12, 0, 1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 1, 0, 3'd5, 8'h40), // R12 store RO
        vec(4'd12, 0, 3, 0, 0, 0, 1, 1, 1, 0, 0, 0, 1, 0, 3'd0, 8'h00), // R12 flush RO
        vec(4'd3,  0, 0, 3, 0, 0, 0, 1, 0, 0, 1, 0, 1, 0, 3'd6, 8'h08), // R3 as-user
        vec(4'd3,  0, 0, 4, 0, 0, 1, 1, 1, 0, 1, 0, 1, 0, 3'd6, 8'h08), // R3 bypass user
        vec(4'd4,  0, 2, 4, 1, 0, 0, 1, 0, 0, 0, 0, 0, 1, 3'd0, 8'h00), // R4 bypass priv
        vec(4'd13, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 1, 0, 3'd3, 8'h20), // R13 range > miss
        vec(4'd13, 0, 0, 0, 0, 0, 1, 1, 0, 1, 1, 0, 1, 0, 3'd1, 8'h00), // R13 miss > priv
        vec(4'd13, 0, 2, 0, 0, 0, 1, 1, 1, 1, 1, 0, 0, 0, 3'd3, 8'h01), // R13 priv > cp
        vec(4'd13, 0, 2, 0, 0, 0, 1, 1, 1, 0, 1, 0, 0, 1, 3'd3, 8'h04), // R13 cp > nfo
        vec(4'd13, 0, 1, 0, 0, 0, 1, 1, 1, 0, 0, 0, 1, 1, 3'd3, 8'h10), // R13 nfo > wprot
        vec(4'd5,  1, 0, 0, 0, 0, 1, 0, 0, 1, 1, 0, 1, 0, 3'd0, 8'h00), // R5 inst off
        vec(4'd3,  0, 0, 2, 1, 0, 1, 1, 1, 0, 1, 0, 1, 0, 3'd0, 8'h00)  // R3 nucleus priv ok
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [30:0] t);
        {req_is_inst, req_op, req_asi, req_priv, req_am, req_va_ok, mmu_en,
         tlb_hit, tlb_p, tlb_w, tlb_e, tlb_cp, tlb_nfo} = t[26:11];
        req_valid = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset valid", {7'd0, out_valid}, 8'd0);
        check("R1 reset verdict", {5'd0, out_verdict}, 8'd0);
        check("R1 reset ftype", out_ftype, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle valid", {7'd0, out_valid}, 8'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VT[i]);
            @(negedge clk);
            check($sformatf("R%0d vec%0d valid", VT[i][30:27], i), {7'd0, out_valid}, 8'd1);
            check($sformatf("R%0d vec%0d verdict", VT[i][30:27], i), {5'd0, out_verdict}, {5'd0, VT[i][10:8]});
            check($sformatf("R%0d vec%0d ftype", VT[i][30:27], i), out_ftype, VT[i][7:0]);
        end

        // R1 hold: a protection fault, then an idle cycle with changed inputs
        apply(VT[15]);
        @(negedge clk);
        req_valid = 1'b0;
        tlb_w = 1'b1; req_op = 2'd0;
        @(negedge clk);
        check("R1 hold valid low", {7'd0, out_valid}, 8'd0);
        check("R1 hold verdict", {5'd0, out_verdict}, 8'd5);
        check("R1 hold ftype", out_ftype, 8'h40);

        // R12 atomic to read-only page
        apply(vec(4'd12, 0, 2, 0, 0, 0, 1, 1, 1, 0, 0, 0, 1, 0, 3'd5, 8'h40));
        @(negedge clk);
        check("R12 atomic RO verdict", {5'd0, out_verdict}, 8'd5);

        // R11 store via normal class on E page is fine
        apply(vec(4'd11, 0, 1, 0, 0, 0, 1, 1, 1, 0, 1, 1, 1, 0, 3'd0, 8'h00));
        @(negedge clk);
        check("R11 store E verdict", {5'd0, out_verdict}, 8'd0);

        // R6 flag out of range while translation off is ignored (R5)
        apply(vec(4'd6, 0, 3, 0, 0, 0, 0, 0, 1, 0, 1, 0, 1, 0, 3'd0, 8'h00));
        @(negedge clk);
        check("R6 R5 off range verdict", {5'd0, out_verdict}, 8'd0);
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 final idle", {7'd0, out_valid}, 8'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule